// File: doc/BRIEF.md
# Interrupt Vector Select and Acknowledge

This block sits between an external interrupt controller and a processor core. It receives two active-low interrupt request lines, one critical and one external, an active-low autovector select and a 16-bit vector offset bus. For each request it accepts, it decides where the handler vector comes from. It outputs a 12-bit handler address offset and a 4-bit context selector, and it sends a one-cycle acknowledge back to the controller.

There are two vector sources. With autovector asserted, the vector comes from one of two internal offset registers that software can write: one register for external requests and one for critical requests. With autovector negated, the vector and the context selector are taken from the offset bus. A critical request wins over an external one that is pending in the same cycle. After an acknowledge, the block accepts nothing more until the core signals ready.

The controller is a state machine with three states:
- `ST_IDLE` waits for a request. The transition *take* goes to `ST_ACK` when a registered request is present and interrupts are enabled.
- `ST_ACK` drives the acknowledge for exactly one cycle. The transition *ack_done* always goes to `ST_WAIT`.
- `ST_WAIT` holds off new requests. The transition *core_rdy* returns to `ST_IDLE` when `core_ready` is high.

Top module: `irq_vector_sel`

## Requirements
- R1: All active-low inputs pass through one register stage. A request driven before rising edge k is taken at edge k+1, and `iack` is high for the cycle that follows edge k+1.
- R2: When autovector is asserted with an external request, `vec_offset` takes bits [15:4] of the external offset register and `ctx_sel` is 0.
- R3: When autovector is asserted with a critical request, `vec_offset` takes bits [15:4] of the critical offset register and `ctx_sel` is 0.
- R4: When autovector is negated, `vec_offset` takes `voff_in[15:4]` and `ctx_sel` takes `voff_in[3:0]`. These are big-endian bus bits 0 to 11 and 12 to 15. The bus is ignored while autovector is asserted.
- R5: When `HAS_CTX` is 0, `ctx_sel` is always 0.
- R6: When both requests are pending in the same sampled cycle, the critical request is taken and `vec_crit` is 1. For an external request, `vec_crit` is 0.
- R7: `iack` is a single-cycle pulse.
- R8: After an acknowledge, no request is taken until `core_ready` has been sampled high in `ST_WAIT`.
- R9: While `int_enable` is low, no request is taken. A request that is still held is taken once the enable rises.
- R10: `cfg_we` writes `cfg_wdata` at the clock edge. `cfg_sel` picks the register: 0 for external, 1 for critical. The new value is used by requests taken at later edges.
- R11: After reset, `iack`, `vec_offset`, `ctx_sel` and `vec_crit` are 0. The offset registers hold `EXT_RST` and `CRIT_RST`.
- R12: `vec_offset`, `ctx_sel` and `vec_crit` change only at the edge that enters `ST_ACK`. They hold their values at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req_n | input | 1 | Critical interrupt request, active low |
| ext_req_n | input | 1 | External interrupt request, active low |
| autovec_n | input | 1 | Autovector select, active low |
| voff_in | input | 16 | External vector offset [15:4] and context [3:0] |
| int_enable | input | 1 | Allows requests to be taken |
| core_ready | input | 1 | Core is ready for the next request |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_sel | input | 1 | Offset register select: 0 external, 1 critical |
| cfg_wdata | input | 16 | Offset register write data |
| vec_offset | output | 12 | Handler address offset |
| ctx_sel | output | 4 | Hardware context selector |
| vec_crit | output | 1 | Taken request was critical |
| iack | output | 1 | Acknowledge pulse |

## Verification
The bench targets the following corner cases:
- **Simultaneous requests.** A design with the priority reversed reports an external vector with `vec_crit` low.
- **Autovector with a busy bus.** The offset bus carries a different value at the same time. A design that ignores the autovector leaks bus bits into `vec_offset` or `ctx_sel`.
- **Requests held through `ST_WAIT`.** A design that does not wait for `core_ready` pulses `iack` again too early.
- **Enable low with a held request.** A design that ignores the enable acknowledges too early, and one that drops held requests never acknowledges.
- **Timing.** A reference model running cycle by cycle catches an acknowledge one cycle early or late, a missing input register, a stretched pulse, and a context leaking out of the instance built without contexts.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_WAIT = 2'd2
    } irqv_state_e;
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/irqv_offset_regs.sv
module irqv_offset_regs #(
    parameter int               OFF_W    = 16,
    parameter logic [OFF_W-1:0] EXT_RST  = '0,
    parameter logic [OFF_W-1:0] CRIT_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [OFF_W-1:0] wdata,
    output logic [OFF_W-1:0] ext_off,
    output logic [OFF_W-1:0] crit_off
);
    localparam int NREG = 2;
    logic [OFF_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [OFF_W-1:0] RV = (g == 0) ? EXT_RST : CRIT_RST;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         regs[g] <= RV;
            else if (we && (int'(sel) == g))    regs[g] <= wdata;
        end
    end

    assign ext_off  = regs[0];
    assign crit_off = regs[1];
endmodule

// File: rtl/irqv_vec_mux.sv
module irqv_vec_mux #(
    parameter int OFF_W   = 16,
    parameter int CTX_W   = 4,
    parameter bit HAS_CTX = 1'b1,
    localparam int ADDR_W = OFF_W - CTX_W
) (
    input  logic              use_crit,
    input  logic              use_auto,
    input  logic [OFF_W-1:0]  bus,
    input  logic [OFF_W-1:0]  ext_off,
    input  logic [OFF_W-1:0]  crit_off,
    output logic [ADDR_W-1:0] addr,
    output logic [CTX_W-1:0]  ctx
);
    logic [OFF_W-1:0] reg_pick;
    logic [OFF_W-1:0] src;

    always_comb begin
        reg_pick = use_crit ? crit_off : ext_off;
        src      = use_auto ? reg_pick : bus;
        addr     = src[OFF_W-1:CTX_W];
    end

    if (HAS_CTX) begin : g_ctx
        assign ctx = use_auto ? '0 : bus[CTX_W-1:0];
    end else begin : g_noctx
        assign ctx = '0;
    end
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
    parameter int               OFF_W    = 16,
    parameter int               CTX_W    = 4,
    parameter bit               HAS_CTX  = 1'b1,
    parameter logic [OFF_W-1:0] EXT_RST  = 16'h1230,
    parameter logic [OFF_W-1:0] CRIT_RST = 16'h0F80,
    localparam int              ADDR_W   = OFF_W - CTX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crit_req_n,
    input  logic              ext_req_n,
    input  logic              autovec_n,
    input  logic [OFF_W-1:0]  voff_in,
    input  logic              int_enable,
    input  logic              core_ready,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [OFF_W-1:0]  cfg_wdata,
    output logic [ADDR_W-1:0] vec_offset,
    output logic [CTX_W-1:0]  ctx_sel,
    output logic              vec_crit,
    output logic              iack
);
    import irqv_pkg::*;

    localparam int SYNC_W = OFF_W + 3;

    logic [SYNC_W-1:0] sync_q;
    logic              crit_s, ext_s, auto_s;
    logic [OFF_W-1:0]  bus_s;
    logic [OFF_W-1:0]  ext_off, crit_off;
    logic [ADDR_W-1:0] mux_addr;
    logic [CTX_W-1:0]  mux_ctx;
    logic              take;
    irqv_state_e       state_q, state_d;

    // R1: a single register stage on the request, autovector and bus inputs
    irqv_sync #(.W(SYNC_W), .RST_VAL({3'b111, {OFF_W{1'b0}}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({crit_req_n, ext_req_n, autovec_n, voff_in}),
        .q     (sync_q)
    );

    always_comb begin
        crit_s = !sync_q[SYNC_W-1];
        ext_s  = !sync_q[SYNC_W-2];
        auto_s = !sync_q[SYNC_W-3];
        bus_s  = sync_q[OFF_W-1:0];
    end

    irqv_offset_regs #(.OFF_W(OFF_W), .EXT_RST(EXT_RST), .CRIT_RST(CRIT_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .ext_off  (ext_off),
        .crit_off (crit_off)
    );

    // R6: the critical request decides the source when both are pending
    irqv_vec_mux #(.OFF_W(OFF_W), .CTX_W(CTX_W), .HAS_CTX(HAS_CTX)) u_mux (
        .use_crit (crit_s),
        .use_auto (auto_s),
        .bus      (bus_s),
        .ext_off  (ext_off),
        .crit_off (crit_off),
        .addr     (mux_addr),
        .ctx      (mux_ctx)
    );

    assign take = int_enable && (crit_s || ext_s);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)       state_d = ST_ACK;
            ST_ACK:                  state_d = ST_WAIT;
            ST_WAIT: if (core_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R12: the vector outputs load only on the take transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_offset <= '0;
            ctx_sel    <= '0;
            vec_crit   <= 1'b0;
        end else if (state_q == ST_IDLE && take) begin
            vec_offset <= mux_addr;
            ctx_sel    <= mux_ctx;
            vec_crit   <= crit_s;
        end
    end

    always_comb begin
        iack = 1'b0;
        unique case (state_q)
            ST_ACK:  iack = 1'b1;
            default: iack = 1'b0;
        endcase
    end

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iack |=> !iack);

    assert_ack_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> $past(int_enable && (crit_s || ext_s)));

    assert_crit_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> (vec_crit == $past(crit_s)));

    assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !core_ready) |=> !iack);

    assert_auto_ctx_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(iack) && $past(auto_s)) |-> (ctx_sel == '0));

    assert_hold_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |-> ($stable(vec_offset) && $stable(ctx_sel) && $stable(vec_crit)));

    assert_no_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_CTX |-> (ctx_sel == '0));
endmodule

// File: tb/tb_irq_vector_sel.sv
module tb_irq_vector_sel;
    localparam logic [15:0] EXT_RST  = 16'h1230;
    localparam logic [15:0] CRIT_RST = 16'h0F80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req_n = 1'b1, ext_req_n = 1'b1, autovec_n = 1'b1;
    logic [15:0] voff_in = '0;
    logic        int_enable = 1'b1, core_ready = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [11:0] vec_offset, vec_offset2;
    logic [3:0]  ctx_sel, ctx_sel2;
    logic        vec_crit, vec_crit2, iack, iack2;

    always #10 clk = ~clk;

    irq_vector_sel #(.HAS_CTX(1'b1), .EXT_RST(EXT_RST), .CRIT_RST(CRIT_RST)) dut (
        .clk(clk), .rst_n(rst_n), .crit_req_n(crit_req_n), .ext_req_n(ext_req_n),
        .autovec_n(autovec_n), .voff_in(voff_in), .int_enable(int_enable),
        .core_ready(core_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vec_offset(vec_offset), .ctx_sel(ctx_sel),
        .vec_crit(vec_crit), .iack(iack));

    irq_vector_sel #(.HAS_CTX(1'b0), .EXT_RST(EXT_RST), .CRIT_RST(CRIT_RST)) dut_noctx (
        .clk(clk), .rst_n(rst_n), .crit_req_n(crit_req_n), .ext_req_n(ext_req_n),
        .autovec_n(autovec_n), .voff_in(voff_in), .int_enable(int_enable),
        .core_ready(core_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vec_offset(vec_offset2), .ctx_sel(ctx_sel2),
        .vec_crit(vec_crit2), .iack(iack2));

    int    checks = 0, errors = 0, cyc = 0;
    string cur_req = "R11";
    bit    started = 1'b0, done = 1'b0;

    // behavioural reference model
    int          m_phase;
    bit          s_crit, s_ext, s_auto;
    logic [15:0] s_bus, m_ext, m_crit, pick;
    logic [11:0] exp_off;
    logic [3:0]  exp_ctx;
    bit          exp_crit, exp_iack;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; s_crit = 0; s_ext = 0; s_auto = 0; s_bus = '0;
            m_ext = EXT_RST; m_crit = CRIT_RST;
            exp_off = '0; exp_ctx = '0; exp_crit = 0;
        end else begin
            started = 1'b1;
            if (m_phase == 0) begin
                if (int_enable && (s_crit || s_ext)) begin
                    exp_crit = s_crit;
                    pick = s_crit ? m_crit : m_ext;
                    if (s_auto) begin
                        exp_off = pick[15:4];
                        exp_ctx = 4'd0;
                    end else begin
                        exp_off = s_bus[15:4];
                        exp_ctx = s_bus[3:0];
                    end
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (core_ready) begin
                m_phase = 0;
            end
            if (cfg_we) begin
                if (cfg_sel) m_crit = cfg_wdata;
                else         m_ext  = cfg_wdata;
            end
            s_crit = !crit_req_n; s_ext = !ext_req_n; s_auto = !autovec_n; s_bus = voff_in;
        end
        exp_iack = (m_phase == 1);
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check(cur_req, "iack (R1 R7)", {31'd0, iack}, {31'd0, exp_iack});
            check(cur_req, "vec_offset (R12)", {20'd0, vec_offset}, {20'd0, exp_off});
            check(cur_req, "ctx_sel", {28'd0, ctx_sel}, {28'd0, exp_ctx});
            check(cur_req, "vec_crit", {31'd0, vec_crit}, {31'd0, exp_crit});
            check("R5", "noctx ctx_sel", {28'd0, ctx_sel2}, 32'd0);
            check("R5", "noctx vec_offset", {20'd0, vec_offset2}, {20'd0, exp_off});
            check("R5", "noctx iack", {31'd0, iack2}, {31'd0, exp_iack});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic release_inputs();
        crit_req_n = 1'b1; ext_req_n = 1'b1; autovec_n = 1'b1; voff_in = 16'h5A5A;
    endtask

    task automatic do_req(string tag, bit c, bit e, bit av, logic [15:0] bus, bit hold);
        bit got = 1'b0;
        cur_req = tag;
        crit_req_n = !c; ext_req_n = !e; autovec_n = !av; voff_in = bus;
        for (int i = 0; i < 8 && !got; i++) begin
            @(negedge clk);
            if (iack) got = 1'b1;
        end
        check(tag, "acknowledge seen", {31'd0, got}, 32'd1);
        if (!hold) release_inputs();
        repeat (3) @(negedge clk);
        core_ready = 1'b1;
        @(negedge clk);
        core_ready = 1'b0;
        release_inputs();
        repeat (3) @(negedge clk);
        core_ready = 1'b1;
        @(negedge clk);
        core_ready = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "reset iack", {31'd0, iack}, 32'd0);
        check("R11", "reset offset", {20'd0, vec_offset}, 32'd0);
        check("R11", "reset ctx", {28'd0, ctx_sel}, 32'd0);
        repeat (2) @(negedge clk);

        do_req("R4", 1'b0, 1'b1, 1'b0, 16'hABC7, 1'b0);
        do_req("R4", 1'b1, 1'b0, 1'b0, 16'h3E59, 1'b0);
        do_req("R2", 1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b0);
        do_req("R3", 1'b1, 1'b0, 1'b1, 16'h7777, 1'b0);
        do_req("R6", 1'b1, 1'b1, 1'b0, 16'h4321, 1'b0);
        do_req("R6", 1'b1, 1'b1, 1'b1, 16'h9999, 1'b0);
        do_req("R8", 1'b0, 1'b1, 1'b0, 16'h0ED3, 1'b1);

        cur_req = "R10";
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'hC0DE;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = 16'h2468;
        @(negedge clk);
        cfg_we = 1'b0;
        do_req("R10", 1'b0, 1'b1, 1'b1, 16'h1111, 1'b0);
        do_req("R10", 1'b1, 1'b0, 1'b1, 16'h2222, 1'b0);

        begin
            int seen = 0;
            cur_req = "R9";
            int_enable = 1'b0;
            ext_req_n = 1'b0; autovec_n = 1'b1; voff_in = 16'h8765;
            repeat (8) begin
                @(negedge clk);
                if (iack) seen++;
            end
            check("R9", "no ack while disabled", seen, 0);
            int_enable = 1'b1;
            do_req("R9", 1'b0, 1'b1, 1'b0, 16'h8765, 1'b0);
        end

        cur_req = "R12";
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule